// File: doc/BRIEF.md
# ROM-to-FIFO Write Sequencer

This block copies a ROM of 2^ADDR_W words into the write port of a dual-clock FIFO, one word per write, in a single pass. It sits entirely in the write clock domain. After reset it waits for a start pulse. It then steps the ROM address and pushes each returned word into the FIFO. When the word from the highest address has been written, it parks in a terminal state. It leaves that state only through reset.

The ROM is synchronous: a word appears on `rom_data` one cycle after its address was presented on `rom_addr`. Address generation therefore runs ahead of the writes. Fetched words wait in a two-entry holding buffer until the FIFO takes them. The FIFO's full flag can stay high for several cycles after the far side has drained entries, and the sequencer simply waits through that. The write request is gated by `fifo_full` in the same cycle, so a word is never offered to a full FIFO. No word is skipped or repeated across a stall.

Top module: `rom_fifo_feeder`

## Requirements
- R1: During and after reset, `fifo_wr_req` is 0 and `rom_addr` is 0. Both stay that way, with no write, until `start` is sampled high on a rising clock edge.
- R2: The k-th write of a pass, counting from 0, carries the ROM word stored at address k on `fifo_wr_data`.
- R3: `fifo_wr_req` is never 1 in a cycle in which `fifo_full` is 1.
- R4: A pass writes exactly 2^ADDR_W words (256 by default), whatever the pattern of full stalls, with no word dropped or duplicated.
- R5: After the write of the word from the last address (0xFF by default), `fifo_wr_req` stays 0 until reset, and a later `start` pulse has no effect.
- R6: With `fifo_full` held low, the first write occurs in the cycle after the second rising edge that follows the edge that sampled `start`. The remaining words are then written in consecutive cycles, so the whole pass occupies 256 adjacent cycles.
- R7: `rom_addr` only ever moves by +1 and never wraps within a pass. It never runs more than two words ahead of the number of words already written, so a long full stall freezes it.
- R8: A reset asserted in the middle of a pass abandons it. A following `start` begins a fresh pass at address 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Write-domain clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begins a pass when sampled high in the idle state |
| rom_addr | output | ADDR_W | Registered address to the synchronous ROM |
| rom_data | input | DATA_W | ROM word for the address presented one cycle earlier |
| fifo_full | input | 1 | FIFO write-side full flag, possibly delayed |
| fifo_wr_req | output | 1 | FIFO write request; a word is taken when high |
| fifo_wr_data | output | DATA_W | Word written into the FIFO with `fifo_wr_req` |

## Verification
The assertions assume that `rom_data` is the word for the address registered one edge earlier. They also assume that the FIFO takes a word in every cycle where `fifo_wr_req` is high, since the request already excludes full cycles. The bench models the ROM as a registered lookup of a computed function. It changes `fifo_full` and `start` only just after a rising edge, so each value holds for a whole cycle. Three `fifo_full` patterns are used: never asserted, pseudo-random, and long bursts held high for tens of cycles to mimic the delayed flag. The monitor follows the expected write index independently of the design and restarts it on every reset.

// File: rtl/feed_pkg.sv
package feed_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_WRITE = 2'd1,
    ST_DONE  = 2'd2
  } feed_state_e;

endpackage

// File: rtl/feed_fetch.sv
// Address generator: issues one ROM read per cycle while the holding buffer
// has room, stops after the last address and never wraps.
module feed_fetch #(
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              run,
  input  logic              room,
  output logic [ADDR_W-1:0] rom_addr,
  output logic              inflight,
  output logic              issued_all
);

  logic fetch;
  logic at_last;

  assign at_last = &rom_addr;
  assign fetch   = run & room & ~issued_all;

  always_ff @(posedge clk) begin
    if (rst) begin
      rom_addr   <= '0;
      inflight   <= 1'b0;
      issued_all <= 1'b0;
    end else begin
      inflight <= fetch;
      if (fetch) begin
        if (at_last) issued_all <= 1'b1;
        else         rom_addr   <= rom_addr + 1'b1;
      end
    end
  end

  // R7: an issued read below the top address moves the address by exactly one
  a_r7_addr_single_step: assert property (@(posedge clk) disable iff (rst)
    (fetch && !at_last) |=> rom_addr == $past(rom_addr) + 1'b1);

  // R7: without a read the address holds (stall freezes it, no wrap at top)
  a_r7_addr_hold: assert property (@(posedge clk) disable iff (rst)
    !fetch |=> $stable(rom_addr));

endmodule

// File: rtl/feed_buf.sv
// Small holding buffer between the one-cycle ROM read and the FIFO write.
// Room is granted against occupancy plus the read still in flight, so a
// returning word always has a slot.
module feed_buf #(
  parameter int DATA_W = 32,
  parameter int DEPTH  = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              push,
  input  logic [DATA_W-1:0] din,
  input  logic              pop,
  output logic [DATA_W-1:0] head,
  output logic              nonempty,
  output logic              room
);

  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = $clog2(DEPTH + 1);
  localparam int OCC_W = CNT_W + 1;

  logic [DATA_W-1:0] slot [DEPTH];
  logic [PTR_W-1:0]  wp;
  logic [PTR_W-1:0]  rp;
  logic [CNT_W-1:0]  cnt;
  logic [OCC_W-1:0]  occ_next;

  function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign nonempty = (cnt != '0);
  assign head     = slot[rp];
  // occupancy after this edge, counting the word that lands from the ROM next
  assign occ_next = OCC_W'(cnt) + OCC_W'(push) - OCC_W'(pop);
  assign room     = (occ_next <= OCC_W'(DEPTH - 1));

  // data storage without reset so it maps onto plain registers or LUT RAM
  always_ff @(posedge clk) begin
    if (push) slot[wp] <= din;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wp  <= '0;
      rp  <= '0;
      cnt <= '0;
    end else begin
      if (push) wp <= bump(wp);
      if (pop)  rp <= bump(rp);
      cnt <= CNT_W'(occ_next);
    end
  end

  // R4: a returning ROM word never finds the buffer full
  a_r4_no_overflow: assert property (@(posedge clk) disable iff (rst)
    (push && !pop) |-> cnt != CNT_W'(DEPTH));

  // R4: the FIFO is never written from an empty buffer
  a_r4_no_underflow: assert property (@(posedge clk) disable iff (rst)
    pop |-> cnt != '0);

endmodule

// File: rtl/feed_fsm.sv
// Pass sequencer: idle until start, write phase counting accepted words,
// terminal state after the last one.
module feed_fsm
  import feed_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        start,
  input  logic        pop,
  output feed_state_e state,
  output logic        in_write
);

  logic [ADDR_W-1:0] wr_cnt;

  assign in_write = (state == ST_WRITE);

  always_ff @(posedge clk) begin
    if (rst) begin
      state  <= ST_IDLE;
      wr_cnt <= '0;
    end else begin
      unique case (state)
        ST_IDLE: begin
          if (start) state <= ST_WRITE;
        end
        ST_WRITE: begin
          if (pop) begin
            wr_cnt <= wr_cnt + 1'b1;
            if (&wr_cnt) state <= ST_DONE;
          end
        end
        ST_DONE: begin
          state <= ST_DONE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // R5: the terminal state is left only by reset
  a_r5_done_sticky: assert property (@(posedge clk) disable iff (rst)
    (state == ST_DONE) |=> (state == ST_DONE));

  // R1: without start the sequencer stays idle
  a_r1_wait_for_start: assert property (@(posedge clk) disable iff (rst)
    (state == ST_IDLE && !start) |=> (state == ST_IDLE));

endmodule

// File: rtl/rom_fifo_feeder.sv
module rom_fifo_feeder
  import feed_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  output logic [ADDR_W-1:0] rom_addr,
  input  logic [DATA_W-1:0] rom_data,
  input  logic              fifo_full,
  output logic              fifo_wr_req,
  output logic [DATA_W-1:0] fifo_wr_data
);

  localparam int BUF_DEPTH = 2;

  feed_state_e state;
  logic        in_write;
  logic        inflight;
  logic        issued_all;
  logic        room;
  logic        nonempty;
  logic        pop;

  feed_fsm #(.ADDR_W(ADDR_W)) u_fsm (
    .clk      (clk),
    .rst      (rst),
    .start    (start),
    .pop      (pop),
    .state    (state),
    .in_write (in_write)
  );

  feed_fetch #(.ADDR_W(ADDR_W)) u_fetch (
    .clk        (clk),
    .rst        (rst),
    .run        (in_write),
    .room       (room),
    .rom_addr   (rom_addr),
    .inflight   (inflight),
    .issued_all (issued_all)
  );

  feed_buf #(.DATA_W(DATA_W), .DEPTH(BUF_DEPTH)) u_buf (
    .clk      (clk),
    .rst      (rst),
    .push     (inflight),
    .din      (rom_data),
    .pop      (pop),
    .head     (fifo_wr_data),
    .nonempty (nonempty),
    .room     (room)
  );

  // the request is qualified by the full flag in the same cycle
  assign pop         = in_write & nonempty & ~fifo_full;
  assign fifo_wr_req = pop;

  // R1: in idle the address generator has not moved
  a_r1_idle_addr_zero: assert property (@(posedge clk) disable iff (rst)
    (state == ST_IDLE) |-> (rom_addr == '0 && !inflight && !nonempty));

  // R5: reaching the terminal state leaves nothing fetched or buffered
  a_r5_done_drained: assert property (@(posedge clk) disable iff (rst)
    (state == ST_DONE) |-> (!nonempty && !inflight && issued_all));

endmodule

// File: tb/sim_rom_fifo_feeder.sv
`timescale 1ns/1ps
module sim_rom_fifo_feeder;

  localparam int DW    = 32;
  localparam int AW    = 8;
  localparam int WORDS = 1 << AW;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          start = 1'b0;
  logic [AW-1:0] rom_addr;
  logic [DW-1:0] rom_q;
  logic          fifo_full = 1'b0;
  logic          fifo_wr_req;
  logic [DW-1:0] fifo_wr_data;

  int n_vec = 0;
  int n_bad = 0;
  int cyc = 0;
  int idx = 0;
  int first_cyc = -1;
  int last_cyc = -1;
  int full_mode = 0;
  logic [15:0] lfsr = 16'hACE1;
  bit  finished = 0;

  always #2 clk = ~clk;

  rom_fifo_feeder #(.DATA_W(DW), .ADDR_W(AW)) u0 (
    .clk          (clk),
    .rst          (rst),
    .start        (start),
    .rom_addr     (rom_addr),
    .rom_data     (rom_q),
    .fifo_full    (fifo_full),
    .fifo_wr_req  (fifo_wr_req),
    .fifo_wr_data (fifo_wr_data)
  );

  function automatic logic [DW-1:0] rom_word(input int a);
    return (32'(a) * 32'h9E3779B1) ^ 32'h5A5A0F0F;
  endfunction

  // behavioural synchronous ROM
  always @(posedge clk) rom_q <= rom_word(int'(rom_addr));

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    n_vec++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  always @(posedge clk) cyc <= cyc + 1;

  // full flag pattern, driven just after the edge
  always @(posedge clk) begin
    #1;
    lfsr <= {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    case (full_mode)
      1:       fifo_full <= lfsr[0] & lfsr[3];
      2:       fifo_full <= ((cyc % 50) < 30);
      default: fifo_full <= 1'b0;
    endcase
  end

  // reference monitor: tracks the expected write index on its own
  always @(negedge clk) begin
    if (rst) begin
      idx = 0;
    end else if (!finished) begin
      check(!(fifo_wr_req && fifo_full), "R3", "request while full", 1, 0);
      check(int'(rom_addr) <= idx + 2, "R7", "address lead over writes",
            rom_addr, idx + 2);
      if (fifo_wr_req) begin
        if (idx >= WORDS) begin
          check(0, "R5", "write after last word", idx, WORDS - 1);
        end else begin
          check(fifo_wr_data == rom_word(idx), "R2", "write data",
                fifo_wr_data, rom_word(idx));
        end
        if (idx == 0) first_cyc = cyc;
        last_cyc = cyc;
        idx = idx + 1;
      end
    end
  end

  task automatic pulse_start(output int s_cyc);
    @(posedge clk); #1;
    start = 1'b1;
    s_cyc = cyc;
    @(posedge clk); #1;
    start = 1'b0;
  endtask

  task automatic wait_writes(input int n, input int limit);
    for (int k = 0; k < limit && idx < n; k++) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic do_reset();
    @(posedge clk); #1;
    rst = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check(fifo_wr_req == 1'b0, "R1", "request in reset", fifo_wr_req, 0);
    check(rom_addr == '0, "R1", "address in reset", rom_addr, 0);
    @(posedge clk); #1;
    rst = 1'b0;
  endtask

  initial begin
    int s_cyc;
    // reset and idle behaviour
    repeat (4) @(posedge clk);
    do_reset();
    repeat (10) begin
      @(negedge clk);
      check(fifo_wr_req == 1'b0 && rom_addr == '0, "R1", "idle without start",
            {fifo_wr_req, rom_addr}, 0);
    end

    // pass A: full never asserted, check timing and count
    full_mode = 0;
    pulse_start(s_cyc);
    wait_writes(WORDS, 1000);
    check(idx == WORDS, "R4", "writes in clean pass", idx, WORDS);
    check(first_cyc == s_cyc + 3, "R6", "first write cycle", first_cyc, s_cyc + 3);
    check(last_cyc == s_cyc + 2 + WORDS, "R6", "last write cycle", last_cyc,
          s_cyc + 2 + WORDS);
    // start again after the terminal state: must be ignored
    pulse_start(s_cyc);
    repeat (40) @(posedge clk);
    @(negedge clk);
    check(idx == WORDS, "R5", "writes after restart attempt", idx, WORDS);
    check(fifo_wr_req == 1'b0, "R5", "request parked", fifo_wr_req, 0);

    // pass B: random full
    do_reset();
    full_mode = 1;
    pulse_start(s_cyc);
    wait_writes(WORDS, 5000);
    check(idx == WORDS, "R4", "writes under random full", idx, WORDS);
    repeat (30) @(posedge clk);
    @(negedge clk);
    check(idx == WORDS, "R5", "no extra writes after random pass", idx, WORDS);

    // pass C: abandoned by reset, then long full bursts
    do_reset();
    full_mode = 1;
    pulse_start(s_cyc);
    wait_writes(40, 2000);
    check(idx >= 40, "R8", "partial pass progress", idx, 40);
    do_reset();
    check(idx == 0, "R8", "index restarted", idx, 0);
    full_mode = 2;
    pulse_start(s_cyc);
    wait_writes(WORDS, 20000);
    check(idx == WORDS, "R8", "fresh pass after mid-run reset", idx, WORDS);
    check(idx == WORDS, "R4", "writes under long stalls", idx, WORDS);
    full_mode = 0;
    repeat (30) @(posedge clk);
    @(negedge clk);
    check(idx == WORDS, "R5", "parked after stalled pass", idx, WORDS);

    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  // watchdog
  initial begin
    #(4 * 150000);
    if (!finished) begin
      n_bad++;
      n_vec++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      finished = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

endmodule